// File: doc/BRIEF.md
# Quadrature Position Counter with Index Reload

This block turns the two phase-shifted channels of an incremental encoder into a signed position count. Four decoding modes are available. Quadrature x4 counts every legal edge on either channel. Quadrature x2 counts every edge on channel A. Quadrature x1 counts once per full cycle. Pulse mode is separate: channel A steps the count up and channel B steps it down. The channel inputs must already be synchronized to `clk`. The block registers the previous channel levels and compares them with the present ones, so each edge is resolved within the timebase cycle in which it is sampled.

A third channel, the index, can reload the count with a programmed value. The reload happens only while the channel levels match a selected quadrature phase and the index is high at the same time. The reload fires once for each unbroken stretch of that condition. A count step always wins over a reload in the same cycle, and the reload then lands on the following cycle.

Arming clears the count and the error flag. A disarmed counter ignores all three channels. The count is a plain register that is valid on every cycle. No data moves through a handshake, so the block has no valid/ready pair and applies no back-pressure; every pin is a level-sensitive control or status pin.

Top module: `quad_index_counter`

## Requirements
- R1: In the first cycle in which `arm` is sampled high after being low, the count becomes INIT (default 0) and `gray_err` clears; that cycle does not count or reload.
- R2: While `arm` is low, the count holds its value whatever the channels do, and no reload happens even when the index condition is met.
- R3: In x4 mode (`mode`=2), every single-channel edge counts. The count goes up by one when the channels differ after an A edge, or are equal after a B edge, so the sequence {A,B} 00→10→11→01→00 counts up. The reverse sequence counts down.
- R4: In x2 mode (`mode`=1), only A edges count: up by one when A and B differ after the edge, down by one otherwise. B edges leave the count unchanged.
- R5: In x1 mode (`mode`=0), only A edges taken while B is low count: a rising A adds one and a falling A subtracts one.
- R6: In pulse mode (`mode`=3), a rising A adds one and a rising B subtracts one. When both rise in the same cycle, the net change is zero.
- R7: In the quadrature modes, a cycle in which A and B change together leaves the count unchanged and sets `gray_err`. The flag stays set until the next arming.
- R8: When {A,B} equals `reload_phase` (bit 1 = A level, bit 0 = B level), `ch_z` is high, `index_en` is high, the counter is armed and no count step occurs, the count takes `reload_val` in that cycle.
- R9: If a count step and a pending reload fall in the same cycle, the step is applied first. The reload is applied one cycle later, provided the condition still holds.
- R10: A reload happens once per unbroken stretch of the index condition. Holding the condition does not reload again.
- R11: After a reload, the next steps count from the reloaded value.
- R12: With `index_en` low, or with the channel levels outside the selected phase, the index channel has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Counter runs while high; a rising level clears it |
| mode | input | 2 | 0 = x1, 1 = x2, 2 = x4, 3 = up/down pulse |
| reload_phase | input | 2 | Channel levels {A,B} that enable the index reload |
| index_en | input | 1 | Enables the index reload |
| reload_val | input | CNT_W | Signed value loaded on index |
| ch_a | input | 1 | Channel A, synchronized |
| ch_b | input | 1 | Channel B, synchronized |
| ch_z | input | 1 | Index channel, synchronized |
| count | output | CNT_W | Signed position count |
| gray_err | output | 1 | Sticky flag for simultaneous A/B change |

## Verification
The properties assume that every channel level is held for at least one full timebase cycle. This means each edge is seen exactly once. They also assume that `mode`, `reload_phase` and `reload_val` change only between the cycles in which they are used. The stimulus drives all inputs on the falling clock edge and changes at most the intended channels per cycle. Simultaneous A/B changes are produced only on purpose, to exercise the error flag. Reloads are tested both on a quiet cycle and on a cycle that also carries a step, using several distinct reload values, including a negative one.

// File: rtl/qic_pkg.sv
package qic_pkg;
  typedef enum logic [1:0] {
    MODE_X1    = 2'd0,
    MODE_X2    = 2'd1,
    MODE_X4    = 2'd2,
    MODE_PULSE = 2'd3
  } qic_mode_e;

  // A phase is the pair of channel levels {A,B}.
  localparam int PHASE_W = 2;
endpackage

// File: rtl/qic_edge_decoder.sv
module qic_edge_decoder
  import qic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ch_a,
  input  logic      ch_b,
  input  qic_mode_e mode,
  output logic      a_q,
  output logic      b_q,
  output logic      step_up,
  output logic      step_dn,
  output logic      illegal
);
  logic a_chg, b_chg, both_chg, differ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= ch_a;
      b_q <= ch_b;
    end
  end

  assign a_chg    = ch_a ^ a_q;
  assign b_chg    = ch_b ^ b_q;
  assign both_chg = a_chg & b_chg;
  assign differ   = ch_a ^ ch_b;

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    illegal = 1'b0;
    unique case (mode)
      MODE_X4: begin
        if (both_chg) begin
          illegal = 1'b1;
        end else if (a_chg) begin
          step_up = differ;
          step_dn = ~differ;
        end else if (b_chg) begin
          step_up = ~differ;
          step_dn = differ;
        end
      end
      MODE_X2: begin
        if (both_chg) begin
          illegal = 1'b1;
        end else if (a_chg) begin
          step_up = differ;
          step_dn = ~differ;
        end
      end
      MODE_X1: begin
        if (both_chg) begin
          illegal = 1'b1;
        end else if (a_chg && !ch_b) begin
          step_up = ch_a;
          step_dn = ~ch_a;
        end
      end
      default: begin
        step_up = ch_a & ~a_q;
        step_dn = ch_b & ~b_q;
      end
    endcase
  end
endmodule

// File: rtl/qic_index_gate.sv
module qic_index_gate
  import qic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               index_en,
  input  logic [PHASE_W-1:0] reload_phase,
  input  logic               ch_a,
  input  logic               ch_b,
  input  logic               ch_z,
  input  logic               step_any,
  output logic               cond,
  output logic               reload_req,
  output logic               load_take
);
  logic done_q;
  logic phase_hit;

  assign phase_hit  = (ch_a == reload_phase[1]) && (ch_b == reload_phase[0]);
  assign cond       = active & index_en & phase_hit & ch_z;
  assign reload_req = cond & ~done_q;
  // Counting wins; the request stays pending while the condition holds.
  assign load_take  = reload_req & ~step_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (!cond)    done_q <= 1'b0;
    else if (load_take) done_q <= 1'b1;
  end
endmodule

// File: rtl/qic_count_reg.sv
module qic_count_reg #(
  parameter int CNT_W = 32,
  parameter int INIT  = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    arm_rise,
  input  logic                    active,
  input  logic                    step_up,
  input  logic                    step_dn,
  input  logic                    illegal,
  input  logic                    load_take,
  input  logic signed [CNT_W-1:0] reload_val,
  output logic signed [CNT_W-1:0] count,
  output logic                    gray_err
);
  localparam logic signed [CNT_W-1:0] INIT_V = CNT_W'(INIT);
  localparam logic signed [CNT_W-1:0] ONE    = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= INIT_V;
    end else if (arm_rise) begin
      count <= INIT_V;
    end else if (active) begin
      if (step_up && !step_dn)      count <= count + ONE;
      else if (step_dn && !step_up) count <= count - ONE;
      else if (load_take)           count <= reload_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gray_err <= 1'b0;
    else if (arm_rise)         gray_err <= 1'b0;
    else if (active && illegal) gray_err <= 1'b1;
  end
endmodule

// File: rtl/quad_index_counter.sv
module quad_index_counter
  import qic_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int INIT  = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    arm,
  input  logic [1:0]              mode,
  input  logic [1:0]              reload_phase,
  input  logic                    index_en,
  input  logic signed [CNT_W-1:0] reload_val,
  input  logic                    ch_a,
  input  logic                    ch_b,
  input  logic                    ch_z,
  output logic signed [CNT_W-1:0] count,
  output logic                    gray_err
);
  logic arm_q, arm_rise, active;
  logic a_q, b_q, step_up, step_dn, illegal, step_any;
  logic cond, reload_req, load_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm;
  end

  assign arm_rise = arm & ~arm_q;
  assign active   = arm & arm_q;
  assign step_any = step_up ^ step_dn;

  qic_edge_decoder u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .ch_a    (ch_a),
    .ch_b    (ch_b),
    .mode    (qic_mode_e'(mode)),
    .a_q     (a_q),
    .b_q     (b_q),
    .step_up (step_up),
    .step_dn (step_dn),
    .illegal (illegal)
  );

  qic_index_gate u_idx (
    .clk          (clk),
    .rst_n        (rst_n),
    .active       (active),
    .index_en     (index_en),
    .reload_phase (reload_phase),
    .ch_a         (ch_a),
    .ch_b         (ch_b),
    .ch_z         (ch_z),
    .step_any     (step_any),
    .cond         (cond),
    .reload_req   (reload_req),
    .load_take    (load_take)
  );

  qic_count_reg #(.CNT_W(CNT_W), .INIT(INIT)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_rise   (arm_rise),
    .active     (active),
    .step_up    (step_up),
    .step_dn    (step_dn),
    .illegal    (illegal),
    .load_take  (load_take),
    .reload_val (reload_val),
    .count      (count),
    .gray_err   (gray_err)
  );
endmodule

// File: rtl/qic_checker.sv
module qic_checker #(
  parameter int CNT_W = 32,
  parameter int INIT  = 0
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    arm,
  input logic                    arm_q,
  input logic [1:0]              mode,
  input logic                    ch_a,
  input logic                    ch_b,
  input logic                    a_q,
  input logic                    b_q,
  input logic signed [CNT_W-1:0] reload_val,
  input logic signed [CNT_W-1:0] count,
  input logic                    gray_err,
  input logic                    cond,
  input logic                    reload_req,
  input logic                    load_take,
  input logic                    step_any
);
  logic act;
  assign act = arm & arm_q;

  a_r1_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !arm_q) |=> (count == CNT_W'(INIT) && !gray_err));

  a_r2_disarmed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(arm) |-> $stable(count));

  a_r3_x4_up: assert property (@(posedge clk) disable iff (!rst_n)
    (act && mode == 2'd2 && (ch_a != a_q) && (ch_b == b_q) && (ch_a != ch_b))
    |=> count == $past(count) + CNT_W'(1));

  a_r6_pulse_up: assert property (@(posedge clk) disable iff (!rst_n)
    (act && mode == 2'd3 && ch_a && !a_q && !(ch_b && !b_q))
    |=> count == $past(count) + CNT_W'(1));

  a_r7_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (act && mode != 2'd3 && (ch_a != a_q) && (ch_b != b_q)) |=> gray_err);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (gray_err && !(arm && !arm_q)) |=> gray_err);

  a_r8_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load_take |=> count == $past(reload_val));

  a_r9_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_req && step_any) |=> (load_take || step_any || !cond));

  a_r10_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
    load_take |=> !load_take);
endmodule

bind quad_index_counter qic_checker #(.CNT_W(CNT_W), .INIT(INIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arm        (arm),
  .arm_q      (arm_q),
  .mode       (mode),
  .ch_a       (ch_a),
  .ch_b       (ch_b),
  .a_q        (a_q),
  .b_q        (b_q),
  .reload_val (reload_val),
  .count      (count),
  .gray_err   (gray_err),
  .cond       (cond),
  .reload_req (reload_req),
  .load_take  (load_take),
  .step_any   (step_any)
);

// File: tb/tb_quad_index_counter.sv
module tb_quad_index_counter;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic [1:0] mode = 2'd2;
  logic [1:0] reload_phase = 2'd0;
  logic index_en = 1'b0;
  logic signed [W-1:0] reload_val = '0;
  logic ch_a = 1'b0, ch_b = 1'b0, ch_z = 1'b0;
  logic signed [W-1:0] count;
  logic gray_err;

  always #5 clk = ~clk;

  quad_index_counter #(.CNT_W(W), .INIT(0)) dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode),
    .reload_phase(reload_phase), .index_en(index_en), .reload_val(reload_val),
    .ch_a(ch_a), .ch_b(ch_b), .ch_z(ch_z), .count(count), .gray_err(gray_err)
  );

  typedef struct {
    logic signed [W-1:0] cnt;
    logic                err;
    string               tag;
  } exp_t;
  exp_t sb[$];

  int total = 0;
  int bad = 0;

  // bench settings, applied at the next driven cycle
  logic m_arm = 1'b0;
  logic [1:0] m_mode = 2'd2, m_ph = 2'd0;
  logic m_en = 1'b0;
  logic signed [W-1:0] m_rv = '0;

  // reference state
  logic ap = 1'b0, bp = 1'b0, armp = 1'b0, done = 1'b0, e_err = 1'b0;
  logic signed [W-1:0] e_cnt = '0;

  task automatic cyc(input logic a, input logic b, input logic z, input string tag);
    logic act, rise, ca, cb, ill, cnd;
    int d;
    exp_t it;
    @(negedge clk);
    arm = m_arm; mode = m_mode; reload_phase = m_ph; index_en = m_en;
    reload_val = m_rv; ch_a = a; ch_b = b; ch_z = z;
    act = m_arm && armp; rise = m_arm && !armp;
    ca = (a != ap); cb = (b != bp); ill = 1'b0; d = 0;
    if (act) begin
      case (m_mode)
        2'd2: if (ca && cb) ill = 1'b1;
              else if (ca) d = (a != b) ? 1 : -1;
              else if (cb) d = (a == b) ? 1 : -1;
        2'd1: if (ca && cb) ill = 1'b1;
              else if (ca) d = (a != b) ? 1 : -1;
        2'd0: if (ca && cb) ill = 1'b1;
              else if (ca && !b) d = a ? 1 : -1;
        default: d = ((a && !ap) ? 1 : 0) - ((b && !bp) ? 1 : 0);
      endcase
    end
    cnd = act && m_en && (a == m_ph[1]) && (b == m_ph[0]) && z;
    if (rise) begin
      e_cnt = '0; e_err = 1'b0;
    end else if (act) begin
      if (ill) e_err = 1'b1;
      if (d != 0) e_cnt = e_cnt + W'(d);
      else if (cnd && !done) begin e_cnt = m_rv; done = 1'b1; end
    end
    if (!cnd) done = 1'b0;
    ap = a; bp = b; armp = m_arm;
    it.cnt = e_cnt; it.err = e_err; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: each driven cycle is resolved at the following rising edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      total++;
      if (count !== it.cnt || gray_err !== it.err) begin
        bad++;
        $display("FAIL %s: count=%0d err=%b expected count=%0d err=%b",
                 it.tag, count, gray_err, it.cnt, it.err);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (count !== '0 || gray_err !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: count=%0d err=%b expected count=0 err=0", count, gray_err);
    end

    // R1: arm
    m_arm = 1'b1; m_mode = 2'd2;
    cyc(0, 0, 0, "R1");
    // R3: x4 forward then reverse
    for (int i = 0; i < 2; i++) begin
      cyc(1, 0, 0, "R3"); cyc(1, 1, 0, "R3"); cyc(0, 1, 0, "R3"); cyc(0, 0, 0, "R3");
    end
    cyc(0, 1, 0, "R3"); cyc(1, 1, 0, "R3"); cyc(1, 0, 0, "R3"); cyc(0, 0, 0, "R3");
    cyc(0, 1, 0, "R3"); cyc(1, 1, 0, "R3");
    // R4: x2
    m_mode = 2'd1;
    cyc(0, 1, 0, "R4"); cyc(0, 0, 0, "R4");
    for (int i = 0; i < 2; i++) begin
      cyc(1, 0, 0, "R4"); cyc(1, 1, 0, "R4"); cyc(0, 1, 0, "R4"); cyc(0, 0, 0, "R4");
    end
    cyc(0, 1, 0, "R4"); cyc(1, 1, 0, "R4"); cyc(1, 0, 0, "R4"); cyc(0, 0, 0, "R4");
    // R5: x1
    m_mode = 2'd0;
    for (int i = 0; i < 3; i++) begin
      cyc(1, 0, 0, "R5"); cyc(1, 1, 0, "R5"); cyc(0, 1, 0, "R5"); cyc(0, 0, 0, "R5");
    end
    for (int i = 0; i < 5; i++) begin
      cyc(0, 1, 0, "R5"); cyc(1, 1, 0, "R5"); cyc(1, 0, 0, "R5"); cyc(0, 0, 0, "R5");
    end
    // R6: pulse mode
    m_mode = 2'd3;
    cyc(1, 0, 0, "R6"); cyc(0, 0, 0, "R6"); cyc(1, 0, 0, "R6"); cyc(0, 0, 0, "R6");
    cyc(0, 1, 0, "R6"); cyc(1, 1, 0, "R6"); cyc(0, 0, 0, "R6"); cyc(1, 1, 0, "R6");
    cyc(0, 0, 0, "R6"); cyc(0, 1, 0, "R6"); cyc(0, 0, 0, "R6");
    // R7: simultaneous change in x4
    m_mode = 2'd2;
    cyc(1, 1, 0, "R7"); cyc(1, 1, 0, "R7");
    cyc(0, 1, 0, "R7"); cyc(0, 0, 0, "R7"); cyc(1, 0, 0, "R7");
    // R2: disarm, channels and index ignored
    m_arm = 1'b0; m_en = 1'b1; m_ph = 2'b00; m_rv = 77;
    cyc(1, 1, 0, "R2"); cyc(0, 1, 0, "R2"); cyc(0, 0, 1, "R2"); cyc(0, 0, 1, "R2");
    cyc(1, 0, 0, "R2");
    // R1: re-arm clears
    m_arm = 1'b1; m_en = 1'b0;
    cyc(0, 0, 0, "R1");
    // R12: index disabled, then phase mismatch
    cyc(0, 0, 1, "R12"); cyc(1, 0, 1, "R12"); cyc(0, 0, 0, "R12");
    m_en = 1'b1; m_ph = 2'b11; m_rv = 50;
    cyc(0, 0, 1, "R12"); cyc(1, 0, 1, "R12"); cyc(0, 0, 1, "R12");
    // R8: reload on a quiet cycle in phase 00
    m_ph = 2'b00; m_rv = 100;
    cyc(0, 0, 0, "R8"); cyc(0, 0, 1, "R8");
    // R10: hold condition, no repeat
    cyc(0, 0, 1, "R10"); cyc(0, 0, 1, "R10");
    // R11: steps continue from reloaded value
    cyc(1, 0, 1, "R11"); cyc(1, 1, 1, "R11"); cyc(0, 1, 1, "R11");
    // R9: step into phase, reload one cycle later
    m_rv = -5;
    cyc(0, 0, 1, "R9"); cyc(0, 0, 1, "R9"); cyc(0, 0, 1, "R10");
    cyc(0, 1, 1, "R11"); cyc(1, 1, 0, "R11");
    // R8: phase 11 reload with a different value
    m_ph = 2'b11; m_rv = 1234;
    cyc(1, 1, 1, "R8"); cyc(1, 1, 0, "R10"); cyc(1, 1, 1, "R8");
    cyc(1, 0, 1, "R11");

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule